// File: doc/BRIEF.md
# Transmit Descriptor Ring Pointer Manager

This block holds the pointer state for one transmit descriptor queue kept as a circular ring in host memory. Software programs a ring base address and a ring length in bytes, enables the queue, and then hands descriptors to hardware by moving the tail pointer forward. Each descriptor takes 16 bytes, so the ring holds length/16 slots. The tail always names the slot one beyond the last descriptor that hardware may use.

The block points the fetch side at the descriptor under the head pointer and turns that pointer into a byte address. When the data for that descriptor has been stored in the on-chip FIFO, a consume strobe moves the head forward by one slot, and the head wraps to zero at the end of the ring. Every slot before the head can be reclaimed by software. The block reports the number of pending descriptors. When a consume empties the queue it sets a sticky interrupt cause, which drives the interrupt output only while the interrupt is enabled.

Top module: `dring_ptr_mgr`

## Requirements
- R1: After reset, base, length, head, tail, control and cause all read as zero, `pending` is 0, and `fetch_req` and `irq` are low.
- R2: Register select encoding: 0 base, 1 length, 2 head (read only), 3 tail, 4 control (bit 0 enable, bit 1 interrupt enable), 5 cause (bit 0, write 1 to clear); other selects read zero. Bits 6:0 of the length register always read zero whatever was written, and the ring holds length/16 slots.
- R3: `fetch_addr` equals base + head × 16. `fetch_req` is high exactly when the queue is enabled and head differs from tail.
- R4: A `stored` pulse while the queue is enabled and not empty moves the head forward by one slot, wrapping from slot count−1 to 0. A pulse when head equals tail leaves the head unchanged.
- R5: `pending` equals (tail − head) modulo the slot count, and it is 0 exactly when head equals tail.
- R6: A tail write whose value is not below the slot count is ignored. A length write clears the tail to zero.
- R7: Writes to base or length are ignored while the queue is enabled.
- R8: Writing control with bit 0 clear while the queue is enabled resets the head to zero. The tail is kept.
- R9: A consume that makes head equal to tail sets the cause bit. Writing 1 to cause bit 0 clears it, and a new set wins over a clear in the same cycle. `irq` is the cause bit gated by the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for the combinational readback |
| rd_data | output | 32 | Readback data |
| stored | input | 1 | The descriptor at the head has been stored on chip |
| fetch_req | output | 1 | A descriptor is ready to be fetched at `fetch_addr` |
| fetch_addr | output | ADDR_W | Byte address of the descriptor at the head |
| pending | output | LEN_W-4 | Number of valid descriptors still pending |
| irq | output | 1 | Queue-empty interrupt after the enable mask |

## Verification
The bench builds the block with ADDR_W = 32 and LEN_W = 10, so the pointers are 6 bits wide. A written length of 0xFF collapses to 128 bytes, which is an 8-slot ring. With a ring that small, the head wrap, the modulo arithmetic of the pending count, and tail values exactly at the slot count (and one above it) are all reached in a few dozen cycles. The same setting also shows the low length bits being dropped and the enable lock on base and length.

// File: rtl/dring_pkg.sv
package dring_pkg;

  // register select encoding used by the write and read ports
  typedef enum logic [2:0] {
    SEL_BASE  = 3'd0,
    SEL_LEN   = 3'd1,
    SEL_HEAD  = 3'd2,
    SEL_TAIL  = 3'd3,
    SEL_CTRL  = 3'd4,
    SEL_CAUSE = 3'd5
  } reg_sel_e;

  localparam int DESC_SHIFT   = 4;  // 16-byte descriptors
  localparam int LEN_LOW_BITS = 7;  // length granule of 128 bytes
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_IE_BIT  = 1;

endpackage

// File: rtl/dring_regs.sv
module dring_regs
  import dring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  localparam int PTR_W = LEN_W - DESC_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [31:0]       wr_data,
  output logic [ADDR_W-1:0] base,
  output logic [LEN_W-1:0]  len,
  output logic [PTR_W-1:0]  count,
  output logic [PTR_W-1:0]  tail,
  output logic              en,
  output logic              ie,
  output logic              dis_pulse,
  output logic              cause_clr
);

  // length with the granule bits forced to zero
  function automatic logic [LEN_W-1:0] len_mask(input logic [31:0] d);
    return {d[LEN_W-1:LEN_LOW_BITS], {LEN_LOW_BITS{1'b0}}};
  endfunction

  logic wr_base, wr_len, wr_tail, wr_ctrl, tail_ok;

  assign count     = len[LEN_W-1:DESC_SHIFT];
  assign wr_base   = wr_en && (reg_sel_e'(wr_sel) == SEL_BASE);
  assign wr_len    = wr_en && (reg_sel_e'(wr_sel) == SEL_LEN);
  assign wr_tail   = wr_en && (reg_sel_e'(wr_sel) == SEL_TAIL);
  assign wr_ctrl   = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
  assign tail_ok   = wr_data < 32'(count);
  assign dis_pulse = wr_ctrl && en && !wr_data[CTRL_EN_BIT];
  assign cause_clr = wr_en && (reg_sel_e'(wr_sel) == SEL_CAUSE) && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0;
      len  <= '0;
      tail <= '0;
      en   <= 1'b0;
      ie   <= 1'b0;
    end else begin
      if (wr_base && !en) base <= wr_data[ADDR_W-1:0];
      if (wr_len && !en) begin
        len  <= len_mask(wr_data);
        tail <= '0;
      end else if (wr_tail && tail_ok) begin
        tail <= wr_data[PTR_W-1:0];
      end
      if (wr_ctrl) begin
        en <= wr_data[CTRL_EN_BIT];
        ie <= wr_data[CTRL_IE_BIT];
      end
    end
  end

  assert_base_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_base && en) |=> $stable(base));
  assert_len_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_len && en) |=> $stable(len));
  assert_tail_in_ring_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tail < count) || (count == '0 && tail == '0));

endmodule

// File: rtl/dring_head.sv
module dring_head #(
  parameter int PTR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             dis_pulse,
  input  logic             stored,
  input  logic [PTR_W-1:0] count,
  input  logic [PTR_W-1:0] tail,
  output logic [PTR_W-1:0] head,
  output logic             adv,
  output logic             empty_evt
);

  // next slot, wrapping at the end of the ring
  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p,
                                                input logic [PTR_W-1:0] n);
    return (p == n - 1'b1) ? '0 : p + 1'b1;
  endfunction

  logic [PTR_W-1:0] head_nxt;
  logic             is_empty;

  assign is_empty  = (head == tail);
  assign adv       = en && stored && !is_empty;
  assign head_nxt  = next_ptr(head, count);
  assign empty_evt = adv && !dis_pulse && (head_nxt == tail);

  always_ff @(posedge clk) begin
    if (!rst_n)         head <= '0;
    else if (dis_pulse) head <= '0;
    else if (adv)       head <= head_nxt;
  end

  assert_head_in_ring_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (head < count) || (head == '0));
  assert_head_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !dis_pulse) |=> (head != $past(head)));
  assert_head_hold_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stored && (head == tail) && !dis_pulse) |=> $stable(head));
  assert_head_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dis_pulse |=> (head == '0));

endmodule

// File: rtl/dring_status.sv
module dring_status #(
  parameter int PTR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] head,
  input  logic [PTR_W-1:0] tail,
  input  logic [PTR_W-1:0] count,
  input  logic             empty_evt,
  input  logic             cause_clr,
  input  logic             ie,
  output logic [PTR_W-1:0] pending,
  output logic             empty,
  output logic             cause,
  output logic             irq
);

  // descriptors between head and tail, modulo the ring size
  function automatic logic [PTR_W-1:0] ring_pending(input logic [PTR_W-1:0] t,
                                                    input logic [PTR_W-1:0] h,
                                                    input logic [PTR_W-1:0] n);
    return (t >= h) ? (t - h) : (t + n - h);
  endfunction

  assign pending = ring_pending(tail, head, count);
  assign empty   = (head == tail);
  assign irq     = cause && ie;

  always_ff @(posedge clk) begin
    if (!rst_n)         cause <= 1'b0;
    else if (empty_evt) cause <= 1'b1;
    else if (cause_clr) cause <= 1'b0;
  end

  assert_cause_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    empty_evt |=> cause);
  assert_cause_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_clr && !empty_evt) |=> !cause);

endmodule

// File: rtl/dring_ptr_mgr.sv
module dring_ptr_mgr
  import dring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  localparam int PTR_W = LEN_W - DESC_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic [2:0]        rd_sel,
  output logic [31:0]       rd_data,
  input  logic              stored,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [PTR_W-1:0]  pending,
  output logic              irq
);

  // byte address of a ring slot
  function automatic logic [ADDR_W-1:0] desc_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [PTR_W-1:0]  p);
    return b + (ADDR_W'(p) << DESC_SHIFT);
  endfunction

  logic [ADDR_W-1:0] base;
  logic [LEN_W-1:0]  len;
  logic [PTR_W-1:0]  count, tail, head;
  logic              en, ie, dis_pulse, cause_clr;
  logic              adv, empty_evt, empty, cause;

  dring_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk, .rst_n, .wr_en, .wr_sel, .wr_data,
    .base, .len, .count, .tail, .en, .ie, .dis_pulse, .cause_clr
  );

  dring_head #(.PTR_W(PTR_W)) u_head (
    .clk, .rst_n, .en, .dis_pulse, .stored, .count, .tail,
    .head, .adv, .empty_evt
  );

  dring_status #(.PTR_W(PTR_W)) u_status (
    .clk, .rst_n, .head, .tail, .count, .empty_evt, .cause_clr, .ie,
    .pending, .empty, .cause, .irq
  );

  assign fetch_req  = en && !empty;
  assign fetch_addr = desc_addr(base, head);

  always_comb begin
    case (reg_sel_e'(rd_sel))
      SEL_BASE:  rd_data = 32'(base);
      SEL_LEN:   rd_data = 32'(len);
      SEL_HEAD:  rd_data = 32'(head);
      SEL_TAIL:  rd_data = 32'(tail);
      SEL_CTRL:  rd_data = {30'd0, ie, en};
      SEL_CAUSE: rd_data = {31'd0, cause};
      default:   rd_data = 32'd0;
    endcase
  end

  assert_no_fetch_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !$past(fetch_req) && $past(rst_n)) |-> (en && pending != '0));
  assert_len_granule_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel_e'(rd_sel) == SEL_LEN) |-> (rd_data[6:0] == 7'd0));

endmodule

// File: tb/test_dring_ptr_mgr.sv
module test_dring_ptr_mgr;

  localparam int ADDR_W = 32;
  localparam int LEN_W  = 10;
  localparam int PTR_W  = LEN_W - 4;

  // op codes of the stimulus table
  localparam logic [2:0] OW = 3'd0, ORD = 3'd1, OC = 3'd2, OP = 3'd3, OA = 3'd4, OI = 3'd5;
  // register selects as stated in R2
  localparam logic [2:0] SB = 3'd0, SL = 3'd1, SH = 3'd2, ST = 3'd3, SC = 3'd4, SX = 3'd5;

  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  sel;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 48;
  localparam vec_t VECS [NV] = '{
    '{ORD, SL, 32'h0,    32'h0,    4'd1},  // R1 length zero
    '{ORD, ST, 32'h0,    32'h0,    4'd1},  // R1 tail zero
    '{OP,  SB, 32'h0,    32'h0,    4'd1},  // R1 pending zero
    '{OW,  SB, 32'h1000, 32'h0,    4'd3},
    '{OW,  SL, 32'hFF,   32'h0,    4'd2},
    '{ORD, SL, 32'h0,    32'h80,   4'd2},  // R2 low bits dropped
    '{OW,  ST, 32'h3,    32'h0,    4'd5},
    '{OP,  SB, 32'h0,    32'h3,    4'd5},  // R5
    '{OA,  SB, 32'h0,    32'h1000, 4'd3},  // R3 disabled, no request
    '{OW,  SC, 32'h3,    32'h0,    4'd3},
    '{OA,  SB, 32'h1,    32'h1000, 4'd3},  // R3
    '{OC,  SB, 32'h0,    32'h0,    4'd4},
    '{OA,  SB, 32'h1,    32'h1010, 4'd3},  // R3 base + 16
    '{ORD, SH, 32'h0,    32'h1,    4'd4},  // R4
    '{OW,  SB, 32'h2000, 32'h0,    4'd7},
    '{ORD, SB, 32'h0,    32'h1000, 4'd7},  // R7 base locked
    '{OW,  SL, 32'h100,  32'h0,    4'd7},
    '{ORD, SL, 32'h0,    32'h80,   4'd7},  // R7 length locked
    '{OC,  SB, 32'h0,    32'h0,    4'd4},
    '{OC,  SB, 32'h0,    32'h0,    4'd4},
    '{OP,  SB, 32'h0,    32'h0,    4'd5},  // R5 empty
    '{OI,  SB, 32'h0,    32'h1,    4'd9},  // R9 empty interrupt
    '{OA,  SB, 32'h0,    32'h1030, 4'd3},  // R3 empty, no request
    '{OC,  SB, 32'h0,    32'h0,    4'd4},
    '{ORD, SH, 32'h0,    32'h3,    4'd4},  // R4 no advance past tail
    '{OW,  SX, 32'h1,    32'h0,    4'd9},
    '{OI,  SB, 32'h0,    32'h0,    4'd9},  // R9 cleared
    '{OW,  ST, 32'h9,    32'h0,    4'd6},
    '{ORD, ST, 32'h0,    32'h3,    4'd6},  // R6 above count ignored
    '{OW,  ST, 32'h8,    32'h0,    4'd6},
    '{ORD, ST, 32'h0,    32'h3,    4'd6},  // R6 equal to count ignored
    '{OW,  ST, 32'h1,    32'h0,    4'd5},
    '{OP,  SB, 32'h0,    32'h6,    4'd5},  // R5 wrapped difference
    '{OC,  SB, 32'h0,    32'h0,    4'd4},
    '{OC,  SB, 32'h0,    32'h0,    4'd4},
    '{OC,  SB, 32'h0,    32'h0,    4'd4},
    '{OC,  SB, 32'h0,    32'h0,    4'd4},
    '{OC,  SB, 32'h0,    32'h0,    4'd4},
    '{ORD, SH, 32'h0,    32'h0,    4'd4},  // R4 wrap to zero
    '{OA,  SB, 32'h1,    32'h1000, 4'd4},  // R4 address after wrap
    '{OP,  SB, 32'h0,    32'h1,    4'd5},  // R5
    '{OC,  SB, 32'h0,    32'h0,    4'd4},
    '{OI,  SB, 32'h0,    32'h1,    4'd9},  // R9
    '{OW,  SC, 32'h2,    32'h0,    4'd8},
    '{ORD, SH, 32'h0,    32'h0,    4'd8},  // R8 head reset
    '{OP,  SB, 32'h0,    32'h1,    4'd8},  // R8 tail kept
    '{OA,  SB, 32'h0,    32'h1000, 4'd8},  // R8 no request
    '{ORD, SX, 32'h0,    32'h1,    4'd9}   // R9 cause readback
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [2:0]        wr_sel = '0;
  logic [31:0]       wr_data = '0;
  logic [2:0]        rd_sel = '0;
  logic [31:0]       rd_data;
  logic              stored = 1'b0;
  logic              fetch_req;
  logic [ADDR_W-1:0] fetch_addr;
  logic [PTR_W-1:0]  pending;
  logic              irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  dring_ptr_mgr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_dring_ptr_mgr (
    .clk, .rst_n, .wr_en, .wr_sel, .wr_data, .rd_sel, .rd_data,
    .stored, .fetch_req, .fetch_addr, .pending, .irq
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input int req, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_consume();
    stored = 1'b1;
    @(negedge clk);
    stored = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    case (v.op)
      OW: do_write(v.sel, v.data);
      OC: do_consume();
      ORD: begin rd_sel = v.sel; #1; chk(rd_data, v.exp, int'(v.req), "readback"); end
      OP: begin #1; chk(32'(pending), v.exp, int'(v.req), "pending"); end
      OA: begin
        #1;
        chk(32'(fetch_req), v.data, int'(v.req), "fetch_req");
        if (v.data[0]) chk(fetch_addr, v.exp, int'(v.req), "fetch_addr");
      end
      OI: begin #1; chk(32'(irq), v.exp, int'(v.req), "irq"); end
      default: ;
    endcase
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(32'(fetch_req), 0, 1, "reset fetch_req");  // R1
    chk(32'(irq), 0, 1, "reset irq");              // R1
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      run_vec(VECS[i]);
    end

    // R1: reset in the middle of operation
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 6; s++) begin
      rd_sel = 3'(s); #1;
      chk(rd_data, 0, 1, "register after reset");
    end
    chk(32'(pending), 0, 1, "pending after reset");
    chk(32'(irq), 0, 1, "irq after reset");

    // R9: cause set with interrupt masked, then unmasked
    @(negedge clk);
    do_write(SL, 32'h80);
    do_write(ST, 32'h1);
    do_write(SC, 32'h1);
    #1 chk(32'(fetch_req), 1, 3, "request before consume");  // R3
    @(negedge clk);
    do_consume();
    #1 chk(32'(irq), 0, 9, "masked irq");
    chk(32'(pending), 0, 5, "pending after consume");  // R5
    @(negedge clk);
    do_write(SC, 32'h3);
    #1 chk(32'(irq), 1, 9, "unmasked irq");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule